// File: doc/BRIEF.md
# Linked-Descriptor Memory-to-FIFO Feeder

This block is the sending side of a DMA channel. Software leaves a chain of 16-byte descriptors in memory and pulses `start` with the address of the first one. The block reads the four words of a descriptor. It forwards the descriptor's 64-bit header, padded with two zero words to a 4-word slot, into a downstream FIFO. It then copies that descriptor's payload words from memory into the FIFO as space permits. It follows the chain at the next 16-byte step until a descriptor carries a stop flag.

Memory is read through a plain port with a fixed read latency of one clock. The FIFO side is a push stream. `fifo_wr_valid` is the only strobe, and `fifo_free` acts as its ready: the block raises `fifo_wr_valid` only while `fifo_free` is nonzero. `fifo_free` may rise at any time, as the consumer drains. It may fall only through this block's own pushes. When the chain ends, `busy` drops. A single-cycle interrupt follows after a delay that grows with the payload moved.

Top module: `fdd_feeder`

## Requirements
- R1: After reset, `busy`, `irq`, `mem_rd_en` and `fifo_wr_valid` are all low.
- R2: A `start` pulse seen while the block is idle and no interrupt is pending raises `busy` on the next cycle and issues a read at `start_addr`. A `start` pulse while busy, or while an interrupt is still pending, has no effect.
- R3: Each descriptor is fetched as four reads at its address +0, +4, +8 and +12. The next descriptor in the chain sits 16 bytes higher.
- R4: Before any payload word of a descriptor, the FIFO receives its word 2, then its word 3, then two zero words.
- R5: Payload is read from the byte address held in bits 23:0 of descriptor word 0, stepping by 4 per word. Bits 29:24 are ignored.
- R6: The payload length is bits 15:0 of descriptor word 1, rounded up to a multiple of 4 words. A length of 0 moves no payload.
- R7: If bit 31 or bit 30 of word 0 is set, the chain stops once that descriptor's payload has been pushed. Otherwise the next descriptor is fetched.
- R8: `fifo_wr_valid` is never high while `fifo_free` is zero. With zero free space, the block stalls without losing or duplicating words.
- R9: `irq` is a one-cycle pulse, raised while `busy` is low. It rises exactly D cycles after `busy` falls, where D is the run's total payload words divided by 4, or 1 if that is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse |
| start_addr | input | 32 | Byte address of the first descriptor |
| busy | output | 1 | Chain in progress |
| irq | output | 1 | Completion pulse |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory byte address |
| mem_rd_data | input | 32 | Read data, valid one cycle after the strobe |
| fifo_wr_valid | output | 1 | FIFO push strobe |
| fifo_wr_data | output | 32 | FIFO push word |
| fifo_free | input | 6 | Free FIFO words, acting as ready |

## Verification
A corrupted descriptor index or source pointer shows up at once: the next `mem_rd_addr` deviates from the expected address sequence on the very read that uses it. A bad header slot or remaining-word count appears as a wrong or missing FIFO word at the moment of the push. A wrong chain decision appears as a stray read after the stop descriptor, or as `busy` held high. A miscounted word total shifts the interrupt by whole cycles, and a delay-counter error does the same. Both are caught at the `irq` edge.

// File: rtl/fdd_pkg.sv
package fdd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRD,
    ST_TWT,
    ST_HDR,
    ST_DRD,
    ST_DWT
  } fdd_state_e;

  localparam int TAG_WORDS = 4;
  localparam int HDR_WORDS = 4;
  localparam int HDR_LIVE  = 2;
  localparam int TAG_STEP  = 4 * TAG_WORDS;
endpackage

// File: rtl/fdd_irq_timer.sv
module fdd_irq_timer #(
  parameter int CNT_W = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic word_inc,
  input  logic finish,
  output logic pending,
  output logic irq
);
  logic [CNT_W-1:0] acc;
  logic [CNT_W-1:0] acc_next;
  logic [CNT_W-1:0] quarter;
  logic [CNT_W-1:0] dly;
  logic             waiting;
  logic             irq_q;

  assign acc_next = acc + CNT_W'(word_inc);
  assign quarter  = acc_next >> 2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      dly     <= '0;
      waiting <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      if (clr) acc <= '0;
      else     acc <= acc_next;
      irq_q <= waiting && (dly == CNT_W'(1));
      if (finish) begin
        waiting <= 1'b1;
        dly     <= (quarter == '0) ? CNT_W'(1) : quarter;
      end else if (waiting) begin
        if (dly == CNT_W'(1)) waiting <= 1'b0;
        else                  dly <= dly - CNT_W'(1);
      end
    end
  end

  assign pending = waiting;
  assign irq     = irq_q;

  assert_one_cycle_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  assert_no_finish_while_waiting_R2: assert property (@(posedge clk) disable iff (!rst_n)
    finish |-> !waiting);
endmodule

// File: rtl/fdd_ctrl.sv
module fdd_ctrl
  import fdd_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int SRC_W  = 24,
  parameter int LEN_W  = 16,
  parameter int FREE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  input  logic              irq_pending,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              fifo_wr_valid,
  output logic [DW-1:0]     fifo_wr_data,
  input  logic [FREE_W-1:0] fifo_free,
  output logic              busy,
  output logic              launch,
  output logic              word_inc,
  output logic              finish
);
  localparam int REM_W = LEN_W + 1;

  fdd_state_e       state;
  logic [1:0]       idx;
  logic [AW-1:0]    tag_addr;
  logic [AW-1:0]    src;
  logic [REM_W-1:0] remain;
  logic             last;
  logic             hdr_done;
  logic [DW-1:0]    tag_w    [TAG_WORDS];
  logic [DW-1:0]    hdr_slot [HDR_WORDS];
  logic [REM_W-1:0] len_rounded;
  logic             room;
  logic             stop_flag;
  fdd_state_e       tail_st;

  for (genvar g = 0; g < HDR_WORDS; g++) begin : g_slot
    if (g < HDR_LIVE) begin : g_live
      assign hdr_slot[g] = tag_w[HDR_LIVE + g];
    end else begin : g_pad
      assign hdr_slot[g] = '0;
    end
  end

  assign room        = (fifo_free != '0);
  assign len_rounded = ({1'b0, tag_w[1][LEN_W-1:0]} + REM_W'(3)) & ~REM_W'(3);
  assign stop_flag   = tag_w[0][DW-1] | tag_w[0][DW-2];
  assign tail_st     = last ? ST_IDLE : ST_TRD;

  assign launch        = (state == ST_IDLE) && start && !irq_pending;
  assign busy          = (state != ST_IDLE);
  assign mem_rd_en     = (state == ST_TRD) || ((state == ST_DRD) && room);
  assign mem_rd_addr   = (state == ST_TRD) ? (tag_addr + AW'({idx, 2'b00})) : src;
  assign fifo_wr_valid = ((state == ST_HDR) && room) || (state == ST_DWT);
  assign fifo_wr_data  = (state == ST_DWT) ? mem_rd_data : hdr_slot[idx];
  assign word_inc      = (state == ST_DWT);
  assign finish        = last && (((state == ST_HDR) && room && (idx == 2'd3) && (remain == '0))
                               || ((state == ST_DWT) && (remain == REM_W'(1))));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      tag_addr <= '0;
      src      <= '0;
      remain   <= '0;
      last     <= 1'b0;
      hdr_done <= 1'b0;
      for (int i = 0; i < TAG_WORDS; i++) tag_w[i] <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (launch) begin
            tag_addr <= start_addr;
            idx      <= '0;
            state    <= ST_TRD;
          end
        end
        ST_TRD: state <= ST_TWT;
        ST_TWT: begin
          tag_w[idx] <= mem_rd_data;
          if (idx == 2'd3) begin
            idx      <= '0;
            tag_addr <= tag_addr + AW'(TAG_STEP);
            src      <= AW'(tag_w[0][SRC_W-1:0]);
            remain   <= len_rounded;
            last     <= stop_flag;
            hdr_done <= 1'b0;
            state    <= ST_HDR;
          end else begin
            idx   <= idx + 2'd1;
            state <= ST_TRD;
          end
        end
        ST_HDR: begin
          if (room) begin
            if (idx == 2'd3) begin
              idx      <= '0;
              hdr_done <= 1'b1;
              state    <= (remain != '0) ? ST_DRD : tail_st;
            end else begin
              idx <= idx + 2'd1;
            end
          end
        end
        ST_DRD: begin
          if (room) begin
            src   <= src + AW'(4);
            state <= ST_DWT;
          end
        end
        ST_DWT: begin
          remain <= remain - REM_W'(1);
          state  <= (remain == REM_W'(1)) ? tail_st : ST_DRD;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_valid |-> (fifo_free != '0));
  assert_start_reads_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> (busy && mem_rd_en && (mem_rd_addr == $past(start_addr))));
  assert_header_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DWT) |-> hdr_done);
  assert_payload_counted_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DWT) |-> (remain != '0));
endmodule

// File: rtl/fdd_feeder.sv
module fdd_feeder #(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int SRC_W      = 24,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 20,
  localparam int FREE_W    = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [AW-1:0]     start_addr,
  output logic              busy,
  output logic              irq,
  output logic              mem_rd_en,
  output logic [AW-1:0]     mem_rd_addr,
  input  logic [DW-1:0]     mem_rd_data,
  output logic              fifo_wr_valid,
  output logic [DW-1:0]     fifo_wr_data,
  input  logic [FREE_W-1:0] fifo_free
);
  logic launch;
  logic word_inc;
  logic finish;
  logic pending;

  fdd_ctrl #(
    .AW(AW), .DW(DW), .SRC_W(SRC_W), .LEN_W(LEN_W), .FREE_W(FREE_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .irq_pending(pending), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .fifo_wr_valid(fifo_wr_valid),
    .fifo_wr_data(fifo_wr_data), .fifo_free(fifo_free), .busy(busy),
    .launch(launch), .word_inc(word_inc), .finish(finish)
  );

  fdd_irq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(launch), .word_inc(word_inc),
    .finish(finish), .pending(pending), .irq(irq)
  );

  assert_irq_while_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !busy);
endmodule

// File: tb/tb_fdd_feeder.sv
module tb_fdd_feeder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic        busy, irq, mem_rd_en, fifo_wr_valid;
  logic [31:0] mem_rd_addr, fifo_wr_data;
  logic [31:0] mem_rd_data = '0;
  logic [5:0]  fifo_free;

  int total = 0, bad = 0, cyc = 0;
  int occ = 0, hold = 0, drain_period = 1, drain_tick = 0;
  int irq_cnt = 0, since = 0, exp_d = 0;
  bit timing = 0, prev_busy = 0;
  logic [31:0] mem_tab [int];
  logic [31:0] exp_rd [$];
  logic [31:0] exp_wr [$];
  string       exp_tag [$];

  fdd_feeder dut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .irq(irq), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .mem_rd_data(mem_rd_data), .fifo_wr_valid(fifo_wr_valid),
    .fifo_wr_data(fifo_wr_data), .fifo_free(fifo_free)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    if (mem_tab.exists(int'(a))) return mem_tab[int'(a)];
    return {~a[15:0], a[15:0]};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, expv);
    end
  endtask

  assign fifo_free = (occ + hold >= 32) ? 6'd0 : 6'(32 - occ - hold);

  always @(posedge clk) begin
    if (mem_rd_en) mem_rd_data <= mem_word(mem_rd_addr);
    drain_tick <= (drain_tick + 1) % drain_period;
    occ <= occ + (fifo_wr_valid ? 1 : 0) - ((drain_tick == 0 && occ > 0) ? 1 : 0);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      chk(0, "watchdog", 32'(cyc), 32'd150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // reference model comparison, every clock
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd_en) begin
        if (exp_rd.size() == 0) chk(0, "R7 unexpected read", mem_rd_addr, 32'hx);
        else begin
          logic [31:0] e;
          e = exp_rd.pop_front();
          chk(mem_rd_addr == e, "R3/R5 read address", mem_rd_addr, e);
        end
      end
      if (fifo_wr_valid) begin
        chk(fifo_free != 0, "R8 push with no room", 32'(fifo_free), 32'd1);
        if (exp_wr.size() == 0) chk(0, "R7 unexpected push", fifo_wr_data, 32'hx);
        else begin
          logic [31:0] e;
          string t;
          e = exp_wr.pop_front();
          t = exp_tag.pop_front();
          chk(fifo_wr_data == e, t, fifo_wr_data, e);
        end
      end
      if (prev_busy && !busy) begin since = 0; timing = 1; end
      else if (timing) since++;
      if (irq) begin
        irq_cnt++;
        chk(timing && since == exp_d, "R9 irq delay", 32'(since), 32'(exp_d));
        timing = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic add_desc(logic [31:0] tag, logic [31:0] w0, logic [31:0] w1,
                          logic [31:0] w2, logic [31:0] w3, inout int words);
    int n;
    logic [31:0] s;
    mem_tab[int'(tag)] = w0;
    mem_tab[int'(tag + 4)] = w1;
    mem_tab[int'(tag + 8)] = w2;
    mem_tab[int'(tag + 12)] = w3;
    for (int i = 0; i < 4; i++) exp_rd.push_back(tag + 32'(4 * i));
    exp_wr.push_back(w2); exp_tag.push_back("R4 header word 2");
    exp_wr.push_back(w3); exp_tag.push_back("R4 header word 3");
    exp_wr.push_back(0);  exp_tag.push_back("R4 pad");
    exp_wr.push_back(0);  exp_tag.push_back("R4 pad");
    n = ((int'(w1[15:0]) + 3) / 4) * 4;
    s = {8'h0, w0[23:0]};
    for (int i = 0; i < n; i++) begin
      exp_rd.push_back(s + 32'(4 * i));
      exp_wr.push_back(mem_word(s + 32'(4 * i)));
      exp_tag.push_back("R5/R6 payload");
    end
    words += n;
  endtask

  task automatic run(logic [31:0] tag, int words, bit poke_busy);
    int w;
    irq_cnt = 0;
    exp_d = (words / 4 == 0) ? 1 : words / 4;
    @(negedge clk);
    start = 1; start_addr = tag;
    @(negedge clk);
    start = 0;
    chk(busy, "R2 busy after start", 32'(busy), 1);
    if (poke_busy) begin
      repeat (5) @(negedge clk);
      start = 1; start_addr = 32'h5000;
      @(negedge clk);
      start = 0;
    end
    w = 0;
    while (busy && w < 3000) begin @(negedge clk); w++; end
    chk(!busy, "R7 chain ends", 32'(busy), 0);
    if (poke_busy) begin
      start = 1; start_addr = 32'h6000;
      @(negedge clk);
      start = 0;
      chk(!busy, "R2 start ignored while irq pending", 32'(busy), 0);
    end
    repeat (exp_d + 12) @(negedge clk);
    chk(irq_cnt == 1, "R9 single irq", 32'(irq_cnt), 1);
    chk(exp_rd.size() == 0, "R3 all reads seen", 32'(exp_rd.size()), 0);
    chk(exp_wr.size() == 0, "R4 all pushes seen", 32'(exp_wr.size()), 0);
    chk(!busy && !irq, "R7 stays idle", {30'd0, busy, irq}, 0);
  endtask

  initial begin
    int words;
    repeat (3) @(negedge clk);
    chk(!busy && !irq && !mem_rd_en && !fifo_wr_valid, "R1 reset state",
        {28'd0, busy, irq, mem_rd_en, fifo_wr_valid}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // single descriptor, IRQ flag, 8 words, start pokes while busy / pending
    words = 0;
    add_desc(32'h1000, 32'h8001_9870, 32'd8, 32'h1111_2222, 32'h3333_4444, words);
    run(32'h1000, words, 1);

    // three-descriptor chain with back-pressure: len 5 -> 8, len 0, len 3 -> 4 with bit 30
    words = 0;
    add_desc(32'h2000, 32'h0F00_0200, 32'd5, 32'hAAAA_0001, 32'hAAAA_0002, words);
    add_desc(32'h2010, 32'h0000_0800, 32'd0, 32'hBBBB_0001, 32'hBBBB_0002, words);
    add_desc(32'h2020, 32'h4000_0300, 32'd3, 32'hCCCC_0001, 32'hCCCC_0002, words);
    hold = 28; drain_period = 4;
    run(32'h2000, words, 0);

    // header-only stop descriptor, FIFO fully blocked first
    words = 0;
    add_desc(32'h3000, 32'h8000_0400, 32'd0, 32'hDDDD_0001, 32'hDDDD_0002, words);
    hold = 32; drain_period = 1;
    @(negedge clk);
    start = 1; start_addr = 32'h3000;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    chk(busy && exp_wr.size() == 4, "R8 stalls with no room", 32'(exp_wr.size()), 4);
    hold = 0;
    exp_d = 1; irq_cnt = 0;
    repeat (30) @(negedge clk);
    chk(irq_cnt == 1, "R9 single irq, minimum delay", 32'(irq_cnt), 1);
    chk(exp_wr.size() == 0 && !busy, "R4 header-only chain done", 32'(exp_wr.size()), 0);

    // length 1 rounds to 4 words
    words = 0;
    add_desc(32'h4000, 32'h4000_0500, 32'd1, 32'hEEEE_0001, 32'hEEEE_0002, words);
    run(32'h4000, words, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule